// File: doc/BRIEF.md
# Bit-Serial Three-Operand Adder

This block adds three operands that arrive one bit per clock, least significant bit first, and returns their sum in the same serial form. In each clock it adds the three incoming bits to a running carry. The low bit of that total leaves as the next sum bit, and the higher bits become the carry for the next bit position. Three operand bits plus a carry can total as much as five, so the carry is held in two flip-flops and can carry a value of 0, 1 or 2 into the next position. The logic between registers is a bit count followed by a small add, so it stays a few small logic cells deep and suits high clock rates.

A word-start marker comes in alongside the first (lowest) bit of each word. On that bit the block ignores any carry left over from the previous word, so words can follow each other without a gap. The marker comes out with a one-cycle delay, aligned with the registered sum bit. A clock enable stalls the whole block: while it is low, neither the carry nor the outputs change. The word length is set entirely by where the markers fall, so any length works. A word of N bits gives its sum modulo 2^N.

Top module: `ser3_adder`

## Requirements
- R1: While reset is high, and after it until the first enabled clock, sum_bit and word_start_out are 0.
- R2: On each enabled clock, sum_bit takes the low bit of (op_bits[0] + op_bits[1] + op_bits[2] + carry) and is seen one clock later.
- R3: The carry passed to the next bit is the total of the three operand bits and the carry, shifted right by one. A carry of 2 is kept and added in full. Example: three all-ones bits after a carry of 2 give sum 1 and carry 2.
- R4: On a clock where word_start_in is 1, the stored carry is treated as 0. After such a clock the carry is at most 1.
- R5: word_start_out equals word_start_in from the previous enabled clock, aligned with the sum bit of that same input bit.
- R6: While clk_en is 0, sum_bit, word_start_out and the carry keep their values, whatever the operand and marker inputs are.
- R7: An N-bit word, sent LSB first with the marker on bit 0, comes out as N sum bits that form (a + b + c) mod 2^N. This holds across stalls and with words sent back to back.
- R8: The carry never goes above 2. After a long run of all-ones bits it stays at 2, and then zero bits output 0, then 1, then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; low stalls carry and outputs |
| word_start_in | input | 1 | High on bit 0 (LSB) of each word |
| op_bits | input | 3 | One bit from each operand; bit k belongs to operand k |
| sum_bit | output | 1 | Registered serial sum bit |
| word_start_out | output | 1 | Registered marker aligned with sum_bit |

## Verification
On every cycle, the assertions check that the carry stays within its two-bit range and is at most 1 just after a word start. They also check that a low enable freezes the carry and both outputs, and that the outgoing marker trails the incoming one by exactly one enabled clock. Whether the sum bits actually form the correct total can only be shown by the scenarios. These are: directed single-bit steps that drive the carry up to 2 and back down, a stall in the middle of a carry, and a scoreboard of random and extreme words with random stalls, reassembled and compared with a modular reference sum.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  // Width needed to hold a count from 0 to n inclusive.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

  // Width of the per-bit total: operands (up to n) plus carry (up to n-1).
  function automatic int total_width(input int n);
    return $clog2(2 * n);
  endfunction
endpackage

// File: rtl/ser3_count.sv
// Counts the ones among the operand bits of the current position.
module ser3_count #(
  parameter int NUM_OPS = 3,
  parameter int CNT_W   = ser3_pkg::count_width(NUM_OPS)
) (
  input  logic [NUM_OPS-1:0] bits,
  output logic [CNT_W-1:0]   count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      count = count + CNT_W'(bits[k]);
    end
  end
endmodule

// File: rtl/ser3_carry.sv
// Multi-valued carry state: adds the bit count to the stored carry and
// keeps the upper bits of the total for the next bit position.
module ser3_carry #(
  parameter int NUM_OPS = 3,
  parameter int CNT_W   = ser3_pkg::count_width(NUM_OPS),
  parameter int TOT_W   = ser3_pkg::total_width(NUM_OPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             sow,
  input  logic [CNT_W-1:0] count,
  output logic             sum_nxt
);
  localparam int CAR_W = TOT_W - 1;
  localparam logic [CAR_W-1:0] CAR_MAX   = CAR_W'(NUM_OPS - 1);
  localparam logic [CAR_W-1:0] FRESH_MAX = CAR_W'(NUM_OPS / 2);

  logic [CAR_W-1:0] carry_q;
  logic [CAR_W-1:0] carry_use;
  logic [TOT_W-1:0] total;

  always_comb begin
    carry_use = sow ? '0 : carry_q;
    total     = TOT_W'(count) + TOT_W'(carry_use);
    sum_nxt   = total[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= '0;
    end else if (ce) begin
      carry_q <= total[TOT_W-1:1];
    end
  end

  // R8
  carry_bound_chk: assert property (@(posedge clk) disable iff (rst)
    carry_q <= CAR_MAX);

  // R4
  fresh_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && sow) |=> (carry_q <= FRESH_MAX));

  // R6
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> $stable(carry_q));
endmodule

// File: rtl/ser3_outreg.sv
// Output register stage: sum bit and aligned word marker.
module ser3_outreg (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic sum_nxt,
  input  logic sow_in,
  output logic sum_bit,
  output logic sow_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_bit <= 1'b0;
      sow_out <= 1'b0;
    end else if (ce) begin
      sum_bit <= sum_nxt;
      sow_out <= sow_in;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce) |=> ($stable(sum_bit) && $stable(sow_out)));

  // R5
  marker_delay_chk: assert property (@(posedge clk) disable iff (rst)
    ce |=> (sow_out == $past(sow_in)));
endmodule

// File: rtl/ser3_adder.sv
// Bit-serial adder of three LSB-first operand streams.
module ser3_adder #(
  parameter int NUM_OPS = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en,
  input  logic               word_start_in,
  input  logic [NUM_OPS-1:0] op_bits,
  output logic               sum_bit,
  output logic               word_start_out
);
  localparam int CNT_W = ser3_pkg::count_width(NUM_OPS);
  localparam int TOT_W = ser3_pkg::total_width(NUM_OPS);

  logic [CNT_W-1:0] ones;
  logic             sum_nxt;

  ser3_count #(.NUM_OPS(NUM_OPS), .CNT_W(CNT_W)) u_count (
    .bits  (op_bits),
    .count (ones)
  );

  ser3_carry #(.NUM_OPS(NUM_OPS), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_carry (
    .clk     (clk),
    .rst     (rst),
    .ce      (clk_en),
    .sow     (word_start_in),
    .count   (ones),
    .sum_nxt (sum_nxt)
  );

  ser3_outreg u_out (
    .clk     (clk),
    .rst     (rst),
    .ce      (clk_en),
    .sum_nxt (sum_nxt),
    .sow_in  (word_start_in),
    .sum_bit (sum_bit),
    .sow_out (word_start_out)
  );
endmodule

// File: tb/test_ser3_adder.sv
module test_ser3_adder;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic       sow = 1'b0;
  logic [2:0] op = '0;
  logic       sum_bit;
  logic       sow_out;

  int nchk  = 0;
  int nfail = 0;
  int cycles = 0;
  bit mon_on = 1'b0;
  bit take = 1'b0;
  logic [W-1:0] sb_q[$];

  always #4 clk = ~clk;

  ser3_adder i_ser3_adder (
    .clk            (clk),
    .rst            (rst),
    .clk_en         (ce),
    .word_start_in  (sow),
    .op_bits        (op),
    .sum_bit        (sum_bit),
    .word_start_out (sow_out)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one input position, return at the negedge where its result shows.
  task automatic step(input logic [2:0] v, input logic s, input logic e);
    ce = e; sow = s; op = v;
    @(negedge clk);
  endtask

  // Driver: pushes the reference sum, then serializes the operands.
  task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] c, input bit stall);
    logic [W-1:0] e;
    e = a + b + c;
    sb_q.push_back(e);
    for (int i = 0; i < W; i++) begin
      if (stall && ($urandom % 4 == 0)) begin
        ce = 1'b0; sow = 1'($urandom); op = 3'($urandom);
        @(negedge clk);
      end
      ce = 1'b1; sow = (i == 0); op = {c[i], b[i], a[i]};
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    take   <= ce && !rst && mon_on;
  end

  // Monitor: reassembles output words and pops expectations.
  initial begin : monitor
    int idx;
    logic [W-1:0] acc;
    logic [W-1:0] exp;
    idx = 0; acc = '0;
    forever begin
      @(negedge clk);
      if (take) begin
        if (idx == 0) check("R5 marker on first bit", W'(sow_out), W'(1));
        else if (sow_out) check("R5 marker inside word", W'(sow_out), W'(0));
        acc[idx] = sum_bit;
        idx++;
        if (idx == W) begin
          if (sb_q.size() == 0) check("R7 unexpected word", acc, '0);
          else begin
            exp = sb_q.pop_front();
            check("R7 word sum", acc, exp);
          end
          idx = 0; acc = '0;
        end
      end
    end
  end

  initial begin : watchdog
    wait (cycles > 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 reset sum", W'(sum_bit), W'(0));
    check("R1 reset marker", W'(sow_out), W'(0));
    rst = 1'b0;
    step(3'b111, 1'b1, 1'b0);
    check("R1 idle after reset", W'({sow_out, sum_bit}), W'(0));

    // Carry climbs to 2 and saturates there.
    step(3'b111, 1'b1, 1'b1);
    check("R2 first bit 3 -> sum 1", W'(sum_bit), W'(1));
    check("R5 marker follows", W'(sow_out), W'(1));
    step(3'b111, 1'b0, 1'b1);
    check("R3 3+1=4 -> sum 0", W'(sum_bit), W'(0));
    check("R5 marker clears", W'(sow_out), W'(0));
    step(3'b111, 1'b0, 1'b1);
    check("R3 3+2=5 -> sum 1", W'(sum_bit), W'(1));
    step(3'b111, 1'b0, 1'b1);
    check("R8 carry stays 2 -> sum 1", W'(sum_bit), W'(1));
    step(3'b000, 1'b0, 1'b1);
    check("R8 zeros after run bit0", W'(sum_bit), W'(0));
    step(3'b000, 1'b0, 1'b1);
    check("R8 zeros after run bit1", W'(sum_bit), W'(1));
    step(3'b000, 1'b0, 1'b1);
    check("R8 zeros after run bit2", W'(sum_bit), W'(0));

    // Word start discards a pending carry of 2.
    step(3'b111, 1'b0, 1'b1);
    step(3'b111, 1'b0, 1'b1);
    step(3'b001, 1'b1, 1'b1);
    check("R4 start drops carry", W'(sum_bit), W'(1));
    step(3'b000, 1'b0, 1'b1);
    check("R4 no carry after start", W'(sum_bit), W'(0));
    step(3'b010, 1'b0, 1'b1);
    check("R2 single one", W'(sum_bit), W'(1));
    step(3'b011, 1'b0, 1'b1);
    check("R2 two ones", W'(sum_bit), W'(0));

    // Stall while carry is 1: outputs and carry frozen.
    step(3'b111, 1'b1, 1'b1);
    check("R6 pre-stall sum", W'(sum_bit), W'(1));
    step(3'b111, 1'b0, 1'b0);
    check("R6 stalled sum", W'({sow_out, sum_bit}), W'(2'b11));
    step(3'b000, 1'b1, 1'b0);
    check("R6 stalled marker", W'({sow_out, sum_bit}), W'(2'b11));
    step(3'b000, 1'b0, 1'b1);
    check("R6 carry kept through stall", W'(sum_bit), W'(1));

    // Scoreboard phase.
    mon_on = 1'b1;
    send_word('1, '1, '1, 1'b0);
    send_word('0, '0, '0, 1'b0);
    send_word('1, '1, '0, 1'b1);
    send_word(8'h80, 8'h80, 8'h80, 1'b0);
    for (int n = 0; n < 40; n++) begin
      send_word(W'($urandom), W'($urandom), W'($urandom), n[0]);
    end
    mon_on = 1'b0;
    ce = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 all words returned", W'(sb_q.size()), W'(0));
    finish_run();
  end
endmodule